// File: doc/BRIEF.md
# Card Host Data FIFO Engine

This block sits between a host bus and a byte-wide card data port and moves transfer data through a circular buffer of 16-bit words. In the transmit direction the host pushes words and the engine sends each word to the card as two bytes, low byte first. In the receive direction the engine merges pairs of card bytes into words, with the first byte in the low half, and the host pops them. Two nested down-counters track the bytes left in the current block and the blocks left in the transfer. When the last byte of the last block moves, the counters reload, the transfer stops and a sticky end-of-transfer flag is raised.

Two programmable 5-bit levels govern the flow. In the receive direction, a fill count above the almost-full level pauses the card port and raises either a receive DMA request or a status flag, chosen by a receive DMA enable. In the transmit direction, a fill count below the almost-empty level raises either a transmit DMA request or a status flag, chosen by a transmit DMA enable. Host reads of an empty buffer set a sticky underrun flag.

Top module: `card_fifo_engine`

## Requirements
- R1: After reset the buffer is empty, both counters are 0, no transfer is active, all flags and requests are low, the almost-full level is 31 and the almost-empty level is 0.
- R2: With `cfg_dir_rx`=0, a host write pushes one word when the fill count is below 32. A write while the buffer holds 32 words is discarded and changes neither the contents nor the count. Host writes are ignored while `cfg_dir_rx`=1.
- R3: In transmit (`cfg_dir_rx`=0), the card port offers bytes only while a transfer is active and the buffer is not empty. Each word goes out as bits [7:0] and then bits [15:8]. A word is removed after its second byte, or after its first byte when that byte ends a block.
- R4: In receive (`cfg_dir_rx`=1), the first card byte of a word lands in bits [7:0] and the second in bits [15:8]. A block ending after the first byte commits the word with bits [15:8] equal to 0.
- R5: Writing `cfg_len_val` with `cfg_blen_we` sets the block length and the byte counter to value+1. Writing it with `cfg_nblk_we` sets the block count and the block counter to value+1 and reloads the byte counter with the block length. When a byte moves and the byte counter reaches zero, the byte counter reloads and the block counter decrements.
- R6: When the block counter reaches zero, it reloads with the block count, `xfer_active` falls in the same cycle and `st_eot` is set. `st_eot` stays set until a `stat_clr` pulse.
- R7: In receive, the card port is not ready for the first byte of a word while the fill count exceeds the almost-full level. While that holds, `dma_rx_req` is high if receive DMA is enabled and `st_af` is high otherwise.
- R8: In transmit, while the fill count is below the almost-empty level, `dma_tx_req` is high if transmit DMA is enabled and `st_ae` is high otherwise.
- R9: While no transfer is active and the buffer is empty, `st_af`, `st_ae`, `dma_rx_req` and `dma_tx_req` are all low.
- R10: A host read in receive with an empty buffer returns the entry at the read pointer, sets the sticky `st_underrun` flag, and moves neither the pointer nor the count. `stat_clr` clears the flag.
- R11: At most one card byte moves per clock, with a valid/ready handshake. A push from one side and a pop from the other in the same cycle leave the fill count unchanged and keep both words intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dir_rx | input | 1 | 1 = receive from card, 0 = transmit to card |
| cfg_len_val | input | 11 | Length value for the block-length or block-count load |
| cfg_blen_we | input | 1 | Load the block length from `cfg_len_val` |
| cfg_nblk_we | input | 1 | Load the block count from `cfg_len_val` |
| cfg_lvl_we | input | 1 | Load the levels and DMA enables |
| cfg_af_lvl | input | 5 | Almost-full level |
| cfg_ae_lvl | input | 5 | Almost-empty level |
| cfg_rx_dma_en | input | 1 | Receive DMA enable |
| cfg_tx_dma_en | input | 1 | Transmit DMA enable |
| xfer_start | input | 1 | Start a transfer when both counters are nonzero |
| stat_clr | input | 1 | Clear the sticky end-of-transfer and underrun flags |
| host_wr | input | 1 | Host word write |
| host_wdata | input | 16 | Host write data |
| host_rd | input | 1 | Host word read (pop) |
| host_rdata | output | 16 | Word at the read pointer |
| crd_rx_valid | input | 1 | Card byte available |
| crd_rx_data | input | 8 | Card byte in |
| crd_rx_ready | output | 1 | Engine accepts a card byte |
| crd_tx_valid | output | 1 | Engine offers a card byte |
| crd_tx_data | output | 8 | Card byte out |
| crd_tx_ready | input | 1 | Card takes the byte |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |
| st_eot | output | 1 | Sticky end of transfer |
| st_af | output | 1 | Almost-full status (receive DMA off) |
| st_ae | output | 1 | Almost-empty status (transmit DMA off) |
| st_underrun | output | 1 | Sticky host read underrun |
| xfer_active | output | 1 | Transfer in progress |
| fill_level | output | 6 | Words held |
| byte_left | output | 12 | Byte counter |
| blk_left | output | 12 | Block counter |

## Verification
The card-side byte that completes a word can land in the same cycle as a host access on the opposite side of the buffer. In transmit, the card pops a word while the host pushes one. In receive, the card commits a word while the host pops. The bench provokes the transmit case by raising `host_wr` in the exact cycle that the second byte of the head word is offered. It judges the result by an unchanged `fill_level` after that edge, by the byte order the card receives, and by reading the pushed word back intact afterwards. The end of a block coinciding with the first byte of a word is also provoked, and is judged by the early pop and the zero high byte.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
    typedef enum logic {
        PH_LO = 1'b0,
        PH_HI = 1'b1
    } byte_phase_e;
endpackage

// File: rtl/cfe_fifo_mem.sv
module cfe_fifo_mem #(
    parameter int AW = 5,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/cfe_xfer_ctr.sv
module cfe_xfer_ctr #(
    parameter int LENW = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LENW-1:0] len_val,
    input  logic            blen_we,
    input  logic            nblk_we,
    input  logic            step,
    output logic [LENW:0]   byte_left,
    output logic [LENW:0]   blk_left,
    output logic            blk_last,
    output logic            xfer_last
);
    localparam int CNTW = LENW + 1;

    typedef struct packed {
        logic [CNTW-1:0] blen;
        logic [CNTW-1:0] nblk;
        logic [CNTW-1:0] bcnt;
        logic [CNTW-1:0] kcnt;
    } ctr_t;

    ctr_t c_q, c_d;
    logic [CNTW-1:0] loaded;

    assign loaded    = CNTW'(len_val) + CNTW'(1);
    assign blk_last  = (c_q.bcnt == CNTW'(1));
    assign xfer_last = blk_last && (c_q.kcnt == CNTW'(1));

    always_comb begin
        c_d = c_q;
        if (blen_we) begin
            c_d.blen = loaded;
            c_d.bcnt = loaded;
        end else if (nblk_we) begin
            c_d.nblk = loaded;
            c_d.kcnt = loaded;
            c_d.bcnt = c_q.blen;
        end else if (step) begin
            if (blk_last) begin
                c_d.bcnt = c_q.blen;
                c_d.kcnt = xfer_last ? c_q.nblk : c_q.kcnt - CNTW'(1);
            end else begin
                c_d.bcnt = c_q.bcnt - CNTW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign byte_left = c_q.bcnt;
    assign blk_left  = c_q.kcnt;
endmodule

// File: rtl/cfe_level_mon.sv
module cfe_level_mon #(
    parameter int AW = 5
) (
    input  logic        active,
    input  logic        dir_rx,
    input  logic [AW:0] fill,
    input  logic [AW-1:0] af_lvl,
    input  logic [AW-1:0] ae_lvl,
    input  logic        rx_dma_en,
    input  logic        tx_dma_en,
    output logic        dma_rx,
    output logic        dma_tx,
    output logic        flag_af,
    output logic        flag_ae
);
    logic idle_empty, af_hit, ae_hit;

    always_comb begin
        idle_empty = !active && (fill == '0);
        af_hit     = !idle_empty && dir_rx  && (fill > {1'b0, af_lvl});
        ae_hit     = !idle_empty && !dir_rx && (fill < {1'b0, ae_lvl});
        dma_rx     = af_hit && rx_dma_en;
        flag_af    = af_hit && !rx_dma_en;
        dma_tx     = ae_hit && tx_dma_en;
        flag_ae    = ae_hit && !tx_dma_en;
    end
endmodule

// File: rtl/card_fifo_engine.sv
module card_fifo_engine
    import cfe_pkg::*;
#(
    parameter int AW   = 5,
    parameter int DW   = 16,
    parameter int LENW = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_dir_rx,
    input  logic [LENW-1:0] cfg_len_val,
    input  logic            cfg_blen_we,
    input  logic            cfg_nblk_we,
    input  logic            cfg_lvl_we,
    input  logic [AW-1:0]   cfg_af_lvl,
    input  logic [AW-1:0]   cfg_ae_lvl,
    input  logic            cfg_rx_dma_en,
    input  logic            cfg_tx_dma_en,
    input  logic            xfer_start,
    input  logic            stat_clr,
    input  logic            host_wr,
    input  logic [DW-1:0]   host_wdata,
    input  logic            host_rd,
    output logic [DW-1:0]   host_rdata,
    input  logic            crd_rx_valid,
    input  logic [DW/2-1:0] crd_rx_data,
    output logic            crd_rx_ready,
    output logic            crd_tx_valid,
    output logic [DW/2-1:0] crd_tx_data,
    input  logic            crd_tx_ready,
    output logic            dma_rx_req,
    output logic            dma_tx_req,
    output logic            st_eot,
    output logic            st_af,
    output logic            st_ae,
    output logic            st_underrun,
    output logic            xfer_active,
    output logic [AW:0]     fill_level,
    output logic [LENW:0]   byte_left,
    output logic [LENW:0]   blk_left
);
    localparam int DEPTH = 1 << AW;
    localparam int CW    = AW + 1;
    localparam int BW    = DW / 2;

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
        byte_phase_e   ph;
        logic [BW-1:0] hold;
        logic          act;
        logic          eot;
        logic          unr;
        logic [AW-1:0] af;
        logic [AW-1:0] ae;
        logic          rxen;
        logic          txen;
    } eng_t;

    eng_t s_q, s_d;

    logic          rx_hs, tx_hs, step, blk_last, xfer_last;
    logic          host_push, host_pop, card_commit, card_pop, push, pop;
    logic          mem_we;
    logic [AW-1:0] wr_ptr;
    logic [DW-1:0] mem_wdata, head;

    cfe_xfer_ctr #(.LENW(LENW)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .len_val   (cfg_len_val),
        .blen_we   (cfg_blen_we),
        .nblk_we   (cfg_nblk_we),
        .step      (step),
        .byte_left (byte_left),
        .blk_left  (blk_left),
        .blk_last  (blk_last),
        .xfer_last (xfer_last)
    );

    cfe_fifo_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (wr_ptr),
        .wdata (mem_wdata),
        .raddr (s_q.rd),
        .rdata (head)
    );

    cfe_level_mon #(.AW(AW)) u_lvl (
        .active    (s_q.act),
        .dir_rx    (cfg_dir_rx),
        .fill      (s_q.cnt),
        .af_lvl    (s_q.af),
        .ae_lvl    (s_q.ae),
        .rx_dma_en (s_q.rxen),
        .tx_dma_en (s_q.txen),
        .dma_rx    (dma_rx_req),
        .dma_tx    (dma_tx_req),
        .flag_af   (st_af),
        .flag_ae   (st_ae)
    );

    // card port: one byte per cycle, direction-gated
    assign crd_rx_ready = s_q.act && cfg_dir_rx &&
                          (s_q.ph == PH_HI || s_q.cnt <= {1'b0, s_q.af});
    assign crd_tx_valid = s_q.act && !cfg_dir_rx && (s_q.cnt != '0);
    assign crd_tx_data  = (s_q.ph == PH_HI) ? head[DW-1:BW] : head[BW-1:0];
    assign host_rdata   = head;

    always_comb begin
        s_d    = s_q;
        rx_hs  = crd_rx_valid && crd_rx_ready;
        tx_hs  = crd_tx_valid && crd_tx_ready;
        step   = rx_hs || tx_hs;
        wr_ptr = s_q.rd + s_q.cnt[AW-1:0];

        host_push   = host_wr && !cfg_dir_rx && (s_q.cnt != CW'(DEPTH));
        host_pop    = host_rd && cfg_dir_rx && (s_q.cnt != '0);
        card_commit = rx_hs && (s_q.ph == PH_HI || blk_last);
        card_pop    = tx_hs && (s_q.ph == PH_HI || blk_last);
        push        = host_push || card_commit;
        pop         = host_pop || card_pop;

        mem_we = push;
        if (card_commit)
            mem_wdata = (s_q.ph == PH_HI) ? {crd_rx_data, s_q.hold}
                                          : {{BW{1'b0}}, crd_rx_data};
        else
            mem_wdata = host_wdata;

        s_d.cnt = s_q.cnt + CW'(push) - CW'(pop);
        if (pop) s_d.rd = s_q.rd + AW'(1);

        if (step) begin
            s_d.ph = (s_q.ph == PH_LO && !blk_last) ? PH_HI : PH_LO;
            if (rx_hs && s_q.ph == PH_LO) s_d.hold = crd_rx_data;
        end

        if (stat_clr) begin
            s_d.eot = 1'b0;
            s_d.unr = 1'b0;
        end
        if (host_rd && cfg_dir_rx && s_q.cnt == '0) s_d.unr = 1'b1;

        if (xfer_start && !s_q.act && byte_left != '0 && blk_left != '0) begin
            s_d.act = 1'b1;
            s_d.ph  = PH_LO;
        end
        if (step && xfer_last) begin
            s_d.act = 1'b0;
            s_d.eot = 1'b1;
        end

        if (cfg_lvl_we) begin
            s_d.af   = cfg_af_lvl;
            s_d.ae   = cfg_ae_lvl;
            s_d.rxen = cfg_rx_dma_en;
            s_d.txen = cfg_tx_dma_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.ph <= PH_LO;
            s_q.af <= '1;
            s_q.ae <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign st_eot      = s_q.eot;
    assign st_underrun = s_q.unr;
    assign xfer_active = s_q.act;
    assign fill_level  = s_q.cnt;
endmodule

// File: rtl/cfe_checker.sv
module cfe_checker #(
    parameter int AW = 5
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_dir_rx,
    input logic        host_rd,
    input logic        crd_rx_ready,
    input logic        crd_tx_valid,
    input logic        crd_tx_ready,
    input logic        dma_rx_req,
    input logic        dma_tx_req,
    input logic        st_eot,
    input logic        st_af,
    input logic        st_ae,
    input logic        st_underrun,
    input logic        xfer_active,
    input logic [AW:0] fill_level
);
    localparam int DEPTH = 1 << AW;

    assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= (AW+1)'(DEPTH));

    assert_full_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == (AW+1)'(DEPTH) && !(host_rd && cfg_dir_rx) &&
         !(crd_tx_valid && crd_tx_ready)) |=> fill_level == (AW+1)'(DEPTH));

    assert_tx_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        crd_tx_valid |-> (fill_level != '0 && xfer_active));

    assert_eot_on_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_active) |-> st_eot);

    assert_af_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_rx_req && st_af));

    assert_ae_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(dma_tx_req && st_ae));

    assert_idle_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_active && fill_level == '0) |->
            !(st_af || st_ae || dma_rx_req || dma_tx_req));

    assert_underrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && cfg_dir_rx && fill_level == '0) |=> st_underrun);

    assert_one_side_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(crd_tx_valid && crd_rx_ready));
endmodule

bind card_fifo_engine cfe_checker #(.AW(AW)) u_cfe_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_dir_rx   (cfg_dir_rx),
    .host_rd      (host_rd),
    .crd_rx_ready (crd_rx_ready),
    .crd_tx_valid (crd_tx_valid),
    .crd_tx_ready (crd_tx_ready),
    .dma_rx_req   (dma_rx_req),
    .dma_tx_req   (dma_tx_req),
    .st_eot       (st_eot),
    .st_af        (st_af),
    .st_ae        (st_ae),
    .st_underrun  (st_underrun),
    .xfer_active  (xfer_active),
    .fill_level   (fill_level)
);

// File: tb/card_fifo_engine_bench.sv
module card_fifo_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_dir_rx = 1'b0;
    logic [10:0] cfg_len_val = '0;
    logic        cfg_blen_we = 1'b0, cfg_nblk_we = 1'b0, cfg_lvl_we = 1'b0;
    logic [4:0]  cfg_af_lvl = 5'd31, cfg_ae_lvl = 5'd0;
    logic        cfg_rx_dma_en = 1'b0, cfg_tx_dma_en = 1'b0;
    logic        xfer_start = 1'b0, stat_clr = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        crd_rx_valid = 1'b0;
    logic [7:0]  crd_rx_data = '0;
    logic        crd_rx_ready, crd_tx_valid, crd_tx_ready;
    logic [7:0]  crd_tx_data;
    logic        dma_rx_req, dma_tx_req, st_eot, st_af, st_ae, st_underrun, xfer_active;
    logic [5:0]  fill_level;
    logic [11:0] byte_left, blk_left;

    int n_cmp = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    assign crd_tx_ready = tx_rdy;
    logic tx_rdy = 1'b0;

    card_fifo_engine u_card_fifo_engine (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_len(int blen_m1, int nblk_m1);
        cfg_len_val = 11'(blen_m1); cfg_blen_we = 1'b1; tick(); cfg_blen_we = 1'b0;
        cfg_len_val = 11'(nblk_m1); cfg_nblk_we = 1'b1; tick(); cfg_nblk_we = 1'b0;
    endtask

    task automatic set_lvl(int af, int ae, bit rxen, bit txen);
        cfg_af_lvl = 5'(af); cfg_ae_lvl = 5'(ae);
        cfg_rx_dma_en = rxen; cfg_tx_dma_en = txen;
        cfg_lvl_we = 1'b1; tick(); cfg_lvl_we = 1'b0;
    endtask

    task automatic start();
        xfer_start = 1'b1; tick(); xfer_start = 1'b0;
    endtask

    task automatic wr_word(logic [15:0] v);
        host_wr = 1'b1; host_wdata = v; tick(); host_wr = 1'b0;
    endtask

    task automatic rd_word(output logic [15:0] v);
        v = host_rdata; host_rd = 1'b1; tick(); host_rd = 1'b0;
    endtask

    task automatic clr();
        stat_clr = 1'b1; tick(); stat_clr = 1'b0;
    endtask

    task automatic rx_feed(int n, logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            int g = 0;
            crd_rx_data = base + 8'(i); crd_rx_valid = 1'b1;
            while (!crd_rx_ready && g < 100) begin tick(); g++; end
            tick();
        end
        crd_rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 fill", 32'(fill_level), 0);
        check("R1 bytes", 32'(byte_left), 0);
        check("R1 blocks", 32'(blk_left), 0);
        check("R1 flags", {st_eot, st_af, st_ae, st_underrun, xfer_active, dma_rx_req, dma_tx_req}, 0);
    endtask

    task automatic t_counters();
        cfg_len_val = 11'd2; cfg_blen_we = 1'b1; tick(); cfg_blen_we = 1'b0;
        check("R5 blen load", 32'(byte_left), 3);
        cfg_len_val = 11'd1; cfg_nblk_we = 1'b1; tick(); cfg_nblk_we = 1'b0;
        check("R5 nblk load", 32'(blk_left), 2);
        cfg_len_val = 11'd4; cfg_blen_we = 1'b1; tick(); cfg_blen_we = 1'b0;
        check("R5 blen reload", 32'(byte_left), 5);
    endtask

    task automatic t_full();
        logic [15:0] v;
        cfg_dir_rx = 1'b0;
        for (int i = 0; i < 33; i++) wr_word(16'h0100 + 16'(i));
        check("R2 full count", 32'(fill_level), 32);
        cfg_dir_rx = 1'b1; wr_word(16'hDEAD);
        check("R2 rx write ignored", 32'(fill_level), 32);
        for (int i = 0; i < 32; i++) begin
            rd_word(v);
            if (i == 0 || i == 31) check("R2 order", 32'(v), 32'h0100 + 32'(i));
        end
        check("R2 drained", 32'(fill_level), 0);
        check("R2 no underrun", 32'(st_underrun), 0);
    endtask

    task automatic t_tx();
        logic [7:0] got [6];
        logic [7:0] exp [6] = '{8'hB2, 8'hA1, 8'hD4, 8'hF6, 8'hE5, 8'h08};
        int k = 0;
        int g = 0;
        cfg_dir_rx = 1'b0;
        wr_word(16'hA1B2); wr_word(16'hC3D4); wr_word(16'hE5F6); wr_word(16'h0708);
        set_len(2, 1);
        tx_rdy = 1'b1;
        start();
        check("R1 ae default zero", 32'(st_ae), 0);
        while (k < 6 && g < 60) begin
            if (crd_tx_valid) begin got[k] = crd_tx_data; k++; end
            tick(); g++;
        end
        tx_rdy = 1'b0;
        for (int i = 0; i < 6; i++) check("R3 tx byte", 32'(got[i]), 32'(exp[i]));
        check("R3 odd block pops word", 32'(fill_level), 0);
        check("R6 stopped", 32'(xfer_active), 0);
        check("R6 eot", 32'(st_eot), 1);
        check("R5 byte reload", 32'(byte_left), 3);
        check("R6 block reload", 32'(blk_left), 2);
        clr();
        check("R6 eot cleared", 32'(st_eot), 0);
    endtask

    task automatic t_rx();
        logic [15:0] v;
        cfg_dir_rx = 1'b1;
        set_len(2, 0);
        start();
        rx_feed(3, 8'h31);
        check("R4 words", 32'(fill_level), 2);
        check("R6 rx eot", 32'(st_eot), 1);
        rd_word(v); check("R4 merge low first", 32'(v), 32'h3231);
        rd_word(v); check("R4 half word", 32'(v), 32'h0033);
        clr();
    endtask

    task automatic t_underrun();
        logic [15:0] v0, v;
        cfg_dir_rx = 1'b1;
        v0 = host_rdata;
        rd_word(v);
        check("R10 stale data", 32'(v), 32'(v0));
        check("R10 head unchanged", 32'(host_rdata), 32'(v0));
        check("R10 count", 32'(fill_level), 0);
        check("R10 flag", 32'(st_underrun), 1);
        clr();
        check("R10 cleared", 32'(st_underrun), 0);
        set_len(1, 0);
        start();
        rx_feed(2, 8'h5A);
        rd_word(v);
        check("R10 pointers intact", 32'(v), 32'h5B5A);
        clr();
    endtask

    task automatic t_af();
        logic [15:0] v;
        cfg_dir_rx = 1'b1;
        set_lvl(2, 0, 0, 0);
        set_len(15, 0);
        start();
        rx_feed(6, 8'h40);
        check("R7 fill", 32'(fill_level), 3);
        check("R7 paused", 32'(crd_rx_ready), 0);
        check("R7 flag", {31'b0, st_af}, 1);
        check("R7 no req", 32'(dma_rx_req), 0);
        set_lvl(2, 0, 1, 0);
        check("R7 req", 32'(dma_rx_req), 1);
        check("R7 flag off", 32'(st_af), 0);
        set_lvl(31, 0, 0, 0);
        check("R7 resumed", 32'(crd_rx_ready), 1);
        rx_feed(10, 8'h46);
        check("R7 done", 32'(xfer_active), 0);
        for (int k = 0; k < 8; k++) begin
            rd_word(v);
            check("R4 rx stream", 32'(v), {16'h0, 8'h41 + 8'(2*k), 8'h40 + 8'(2*k)});
        end
        clr();
    endtask

    task automatic t_collide();
        logic [7:0] got [4];
        logic [15:0] v;
        cfg_dir_rx = 1'b0;
        wr_word(16'h1234); wr_word(16'h5678);
        set_len(3, 0);
        tx_rdy = 1'b1;
        start();
        got[0] = crd_tx_data; tick();
        got[1] = crd_tx_data;
        host_wr = 1'b1; host_wdata = 16'h9ABC; tick(); host_wr = 1'b0;
        check("R11 push+pop count", 32'(fill_level), 2);
        got[2] = crd_tx_data; tick();
        got[3] = crd_tx_data; tick();
        tx_rdy = 1'b0;
        check("R11 bytes", {got[0], got[1], got[2], got[3]}, 32'h34127856);
        check("R11 left", 32'(fill_level), 1);
        cfg_dir_rx = 1'b1;
        rd_word(v);
        check("R11 pushed word", 32'(v), 32'h9ABC);
        clr();
    endtask

    task automatic t_ae();
        logic [15:0] v;
        cfg_dir_rx = 1'b0;
        set_lvl(31, 3, 0, 0);
        wr_word(16'hAAAA);
        set_len(1, 0);
        start();
        check("R8 flag", 32'(st_ae), 1);
        check("R8 no req", 32'(dma_tx_req), 0);
        set_lvl(31, 3, 0, 1);
        check("R8 req", 32'(dma_tx_req), 1);
        check("R8 flag off", 32'(st_ae), 0);
        wr_word(16'hBBBB); wr_word(16'hCCCC);
        check("R8 at level", {30'b0, dma_tx_req, st_ae}, 0);
        tx_rdy = 1'b1; tick(); tick(); tx_rdy = 1'b0;
        check("R8 idle nonempty", 32'(dma_tx_req), 1);
        cfg_dir_rx = 1'b1;
        rd_word(v); rd_word(v);
        cfg_dir_rx = 1'b0; #1;
        check("R9 idle empty req", 32'(dma_tx_req), 0);
        set_lvl(31, 3, 0, 0);
        check("R9 idle empty flag", {30'b0, st_ae, st_af}, 0);
        clr();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_counters();
        t_full();
        t_tx();
        t_rx();
        t_underrun();
        t_af();
        t_collide();
        t_ae();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    end
endmodule